// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor timer of a local interrupt controller. Software programs three things through simple write strobes: a starting count, a divider code and a timer vector entry. The vector entry holds a mask flag, a one-shot/periodic flag and an 8-bit vector. The timer then counts down in divided ticks of the block clock. When the count runs out, it raises a single-cycle interrupt request that carries the programmed vector. The present count can be read back at any time.

Every divided tick is counted from the cycle in which the starting count was written. As a result, periodic expiries stay locked to that load cycle and never drift. A hard reset or a soft init pulse returns the timer to a quiet, masked state. Any expiry that was pending is dropped.

Top module: `lic_timer`

## Requirements
- R1: After reset the readback count is 0, no request is raised, and the vector entry is masked. A count loaded before any vector write therefore never raises a request.
- R2: The 3-bit divider code selects a divisor as follows: codes 0 to 6 select 2, 4, 8, 16, 32, 64 and 128, and code 7 selects 1. Until the first divider write after reset or init, the divisor is 1.
- R3: A count write restarts the timer from the written value. The readback shows that value in the cycle after the write.
- R4: In one-shot mode, a count N loaded with divisor D raises a request (N+1)·D cycles after the load edge. The readback then stays 0 and no later request follows.
- R5: In periodic mode, requests recur every (N+1)·D cycles, measured from the load edge. The readback reloads to N at each expiry.
- R6: A loaded count of 0 never raises a request in either mode and reads back 0. Loading 0 stops a timer that is running.
- R7: While the mask flag is set, expiries raise no request but counting continues. A one-shot expiry that happens while masked is consumed, so clearing the mask afterwards raises nothing.
- R8: A request lasts exactly one cycle, and irq_vector holds the entry's vector during it.
- R9: An init pulse clears the count, cancels any pending expiry, masks the entry and returns the divisor to 1. Init wins over a count write in the same cycle.
- R10: A mode change made while the timer runs does not restart the count. Switching from periodic to one-shot gives one more expiry at the time aligned to the load, then none.
- R11: With divisor D, the readback j cycles after the load equals N minus floor(j/D), for j below (N+1)·D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the timer's time base |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Soft init pulse; same clearing as reset |
| cnt_wr | input | 1 | Strobe: load a new starting count |
| cnt_wdata | input | CNT_W | Starting count value |
| div_wr | input | 1 | Strobe: write the divider code |
| div_code | input | 3 | Divider code (see R2) |
| lvt_wr | input | 1 | Strobe: write the timer vector entry |
| lvt_mask | input | 1 | Entry mask flag (1 = masked) |
| lvt_periodic | input | 1 | Entry mode flag (1 = periodic, 0 = one-shot) |
| lvt_vector | input | 8 | Entry vector |
| cur_count | output | CNT_W | Present count readback |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The countdown is exercised with several small starting counts under a range of divider codes: code 7, which divides by one, and codes 0, 1, 3 and 6. Because the expected expiry time scales with (N+1)·D, a wrong code mapping or an off-by-one in the period shows up as a different cycle count. Readback samples taken just before and just after each tick boundary separate load-aligned ticking from ticking that starts late or early. The same count is also run in several variants: one-shot against periodic, masked against unmasked, zero against non-zero, and with a mode flip or an init pulse in mid-count. Comparing these runs separates the reload, stop, consume and cancel paths from one another.

// File: rtl/lic_timer_pkg.sv
// Package: shared types and helpers of the local interrupt timer.
// Assumes: a 3-bit divider code and an 8-bit vector.
package lic_timer_pkg;

    localparam int unsigned VEC_W   = 8;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned SHIFT_W = 3;

    // Timer vector entry as held in the block.
    typedef struct packed {
        logic             masked;
        logic             periodic;
        logic [VEC_W-1:0] vector;
    } lvt_entry_t;

    // Divider code to shift amount: codes 0..6 give 1..7, code 7 gives 0.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        logic [SHIFT_W-1:0] s;
        case (code)
            3'd0:    s = 3'd1;
            3'd1:    s = 3'd2;
            3'd2:    s = 3'd3;
            3'd3:    s = 3'd4;
            3'd4:    s = 3'd5;
            3'd5:    s = 3'd6;
            3'd6:    s = 3'd7;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lic_timer_regs.sv
// Module: programming state of the timer (vector entry, shift, starting count).
// Assumes: write strobes are single-cycle and init has priority over every write.
module lic_timer_regs
    import lic_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                cnt_wr,
    input  logic [CNT_W-1:0]    cnt_wdata,
    input  logic                div_wr,
    input  logic [CODE_W-1:0]   div_code,
    input  logic                lvt_wr,
    input  lvt_entry_t          lvt_wdata,
    output lvt_entry_t          lvt_q,
    output logic [SHIFT_W-1:0]  shift_q,
    output logic [CNT_W-1:0]    ic_q,
    output logic                restart
);

    localparam lvt_entry_t LVT_RESET = '{masked: 1'b1, periodic: 1'b0, vector: '0};

    // A count write that is not overridden by init restarts the timer.
    assign restart = cnt_wr & ~init;

    // Vector entry: masked on reset or init, else follows writes.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            lvt_q <= LVT_RESET;
        end else if (lvt_wr) begin
            lvt_q <= lvt_wdata;
        end
    end

    // Shift amount: zero (divide by one) on reset or init, else decoded from the code.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            shift_q <= '0;
        end else if (div_wr) begin
            shift_q <= code_to_shift(div_code);
        end
    end

    // Starting count: cleared on reset or init, captured on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            ic_q <= '0;
        end else if (restart) begin
            ic_q <= cnt_wdata;
        end
    end

endmodule

// File: rtl/lic_timer_prescale.sv
// Module: divided-tick generator aligned to the load cycle.
// Assumes: clear is raised in the load cycle, so tick k falls exactly
// k * 2**shift cycles after the load edge.
module lic_timer_prescale #(
    parameter int unsigned SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int unsigned PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // One mask bit per prescaler stage: set for stages below the shift amount.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign low_mask[i] = (SHIFT_W'(i) < shift);
    end

    // Cycle counter since the load; wraps freely between loads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // A tick occurs when all selected low bits are ones (the next value rolls them over).
    assign tick = &(pre_q | ~low_mask);

endmodule

// File: rtl/lic_timer_core.sv
// Module: countdown, expiry detection and request pulse.
// Assumes: ic is non-zero whenever run_q is set; restart and init are never
// raised together (init is already folded into restart upstream).
module lic_timer_core
    import lic_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              restart,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              tick,
    input  lvt_entry_t        lvt,
    input  logic [CNT_W-1:0]  ic,
    output logic [CNT_W-1:0]  cur_q,
    output logic              run_q,
    output logic              irq_q,
    output logic [VEC_W-1:0]  vec_q
);

    logic expire;

    // Expiry: a tick arrives while running with the count already at zero.
    assign expire = run_q & tick & (cur_q == '0);

    // Countdown register and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            cur_q <= '0;
            run_q <= 1'b0;
        end else if (restart) begin
            cur_q <= load_val;
            run_q <= (load_val != '0);
        end else if (expire) begin
            if (lvt.periodic) begin
                cur_q <= ic;
            end else begin
                run_q <= 1'b0;
            end
        end else if (run_q && tick) begin
            cur_q <= cur_q - 1'b1;
        end
    end

    // Request pulse: one cycle per unmasked expiry, dropped on restart or init.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire & ~restart & ~lvt.masked;
        end
    end

    // Vector latch: captured with each expiry so it is valid with the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (expire) begin
            vec_q <= lvt.vector;
        end
    end

endmodule

// File: rtl/lic_timer.sv
// Module: top of the local interrupt controller timer.
// Assumes: one clock domain; clk is the timer time base; synchronous active-low reset.
module lic_timer
    import lic_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              cnt_wdata,
    input  logic                          div_wr,
    input  logic [2:0]                    div_code,
    input  logic                          lvt_wr,
    input  logic                          lvt_mask,
    input  logic                          lvt_periodic,
    input  logic [7:0]                    lvt_vector,
    output logic [CNT_W-1:0]              cur_count,
    output logic                          irq,
    output logic [7:0]                    irq_vector
);

    lvt_entry_t          lvt_wdata;
    lvt_entry_t          lvt_q;
    logic [SHIFT_W-1:0]  shift_q;
    logic [CNT_W-1:0]    ic_q;
    logic                restart;
    logic                tick;
    logic                run_q;

    // Gather the entry fields into one record.
    assign lvt_wdata = '{masked: lvt_mask, periodic: lvt_periodic, vector: lvt_vector};

    lic_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .div_wr    (div_wr),
        .div_code  (div_code),
        .lvt_wr    (lvt_wr),
        .lvt_wdata (lvt_wdata),
        .lvt_q     (lvt_q),
        .shift_q   (shift_q),
        .ic_q      (ic_q),
        .restart   (restart)
    );

    lic_timer_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart | init),
        .shift (shift_q),
        .tick  (tick)
    );

    lic_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .restart  (restart),
        .load_val (cnt_wdata),
        .tick     (tick),
        .lvt      (lvt_q),
        .ic       (ic_q),
        .cur_q    (cur_count),
        .run_q    (run_q),
        .irq_q    (irq),
        .vec_q    (irq_vector)
    );

endmodule

// File: rtl/lic_timer_chk.sv
// Checker: temporal properties of the timer, bound to the top module.
// Assumes: inputs are held low during reset.
module lic_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq,
    input logic             mask_q,
    input logic             periodic_q,
    input logic [CNT_W-1:0] ic_q,
    input logic             run_q
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                   // R8

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask_q));                                         // R7

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ic_q) != '0));                                    // R6

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init) |-> (!irq && cur_count == '0 && mask_q));            // R9

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr && !init) |-> (cur_count == $past(cnt_wdata)));     // R3

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(periodic_q)) |-> (cur_count == '0 && !run_q));    // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) && !$past(cnt_wr) && !$past(init) && $past(cur_count) != '0)
        |-> (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1)); // R11

endmodule

bind lic_timer lic_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (init),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cur_count  (cur_count),
    .irq        (irq),
    .mask_q     (lvt_q.masked),
    .periodic_q (lvt_q.periodic),
    .ic_q       (ic_q),
    .run_q      (run_q)
);

// File: tb/sim_lic_timer.sv
// Bench: directed scenarios, one task each; inputs driven and outputs sampled at negedge.
module sim_lic_timer;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init = 1'b0;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             div_wr = 1'b0;
    logic [2:0]       div_code = '0;
    logic             lvt_wr = 1'b0;
    logic             lvt_mask = 1'b0;
    logic             lvt_periodic = 1'b0;
    logic [7:0]       lvt_vector = '0;
    logic [CNT_W-1:0] cur_count;
    logic             irq;
    logic [7:0]       irq_vector;

    int nchk  = 0;
    int nfail = 0;

    always #2 clk = ~clk;  // 250 MHz

    lic_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .init(init),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .div_wr(div_wr), .div_code(div_code),
        .lvt_wr(lvt_wr), .lvt_mask(lvt_mask), .lvt_periodic(lvt_periodic), .lvt_vector(lvt_vector),
        .cur_count(cur_count), .irq(irq), .irq_vector(irq_vector)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All write tasks start at a negedge and return at the next one.
    task automatic wr_count(input int v);
        cnt_wr = 1'b1; cnt_wdata = CNT_W'(v);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_div(input int code);
        div_wr = 1'b1; div_code = 3'(code);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wr_lvt(input bit m, input bit p, input int v);
        lvt_wr = 1'b1; lvt_mask = m; lvt_periodic = p; lvt_vector = 8'(v);
        @(negedge clk);
        lvt_wr = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Negedges until irq is seen (at least one step); returns max on timeout.
    task automatic wait_irq(input int max, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq && k < max);
    endtask

    // Count irq pulses over n negedges.
    task automatic count_irq(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) hits++;
        end
    endtask

    task automatic t_reset();
        int h;
        chk(cur_count == 0, "R1 count", cur_count, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        wr_count(3);
        step(2);
        chk(cur_count == 1, "R2 default divide by one", cur_count, 1);
        count_irq(12, h);
        chk(h == 0, "R1 masked after reset", h, 0);
    endtask

    task automatic t_oneshot();
        int k, h;
        wr_lvt(1'b0, 1'b0, 8'h41);
        wr_div(0);
        wr_count(4);
        wait_irq(100, k);
        chk(k == 10, "R4 one-shot expiry time", k, 10);
        chk(irq_vector == 8'h41, "R8 vector", irq_vector, 8'h41);
        step(1);
        chk(irq == 1'b0, "R8 single cycle", irq, 0);
        chk(cur_count == 0, "R4 reads zero", cur_count, 0);
        count_irq(30, h);
        chk(h == 0, "R4 no repeat", h, 0);
    endtask

    task automatic t_divmap();
        int codes[4] = '{7, 1, 3, 6};
        int shifts[4] = '{0, 2, 4, 7};
        int k;
        wr_lvt(1'b0, 1'b0, 8'h10);
        for (int i = 0; i < 4; i++) begin
            wr_div(codes[i]);
            wr_count(2);
            wait_irq(1000, k);
            chk(k == (3 << shifts[i]), "R2 divider code", k, 3 << shifts[i]);
            step(1);
        end
    endtask

    task automatic t_periodic();
        int k;
        wr_lvt(1'b0, 1'b1, 8'h22);
        wr_div(7);
        wr_count(5);
        for (int i = 0; i < 3; i++) begin
            wait_irq(100, k);
            chk(k == 6, "R5 period", k, 6);
            chk(cur_count == 5, "R5 reload", cur_count, 5);
            chk(irq_vector == 8'h22, "R8 periodic vector", irq_vector, 8'h22);
        end
    endtask

    task automatic t_mode();
        int k, h;
        wr_lvt(1'b0, 1'b1, 8'h33);
        wr_div(7);
        wr_count(3);
        wait_irq(100, k);
        chk(k == 4, "R5 first period", k, 4);
        wr_lvt(1'b0, 1'b0, 8'h33);
        wait_irq(100, k);
        chk(k == 3, "R10 aligned expiry after mode change", k, 3);
        count_irq(20, h);
        chk(h == 0, "R10 one-shot after switch", h, 0);
        chk(cur_count == 0, "R10 stopped", cur_count, 0);
    endtask

    task automatic t_zero();
        int h;
        wr_lvt(1'b0, 1'b1, 8'h50);
        wr_count(0);
        count_irq(40, h);
        chk(h == 0, "R6 periodic zero silent", h, 0);
        chk(cur_count == 0, "R6 zero readback", cur_count, 0);
        wr_lvt(1'b0, 1'b0, 8'h50);
        wr_count(10);
        step(3);
        wr_count(0);
        count_irq(40, h);
        chk(h == 0, "R6 zero stops one-shot", h, 0);
        chk(cur_count == 0, "R6 stopped readback", cur_count, 0);
    endtask

    task automatic t_mask();
        int h;
        wr_lvt(1'b1, 1'b1, 8'h60);
        wr_div(7);
        wr_count(3);
        step(1);
        chk(cur_count == 2, "R7 counts while masked", cur_count, 2);
        count_irq(20, h);
        chk(h == 0, "R7 masked periodic silent", h, 0);
        wr_lvt(1'b1, 1'b0, 8'h60);
        wr_count(3);
        step(8);
        wr_lvt(1'b0, 1'b0, 8'h60);
        count_irq(20, h);
        chk(h == 0, "R7 masked expiry consumed", h, 0);
        chk(cur_count == 0, "R7 readback after consumed", cur_count, 0);
    endtask

    task automatic t_init();
        int h;
        wr_lvt(1'b0, 1'b0, 8'h70);
        wr_div(7);
        wr_count(5);
        step(2);
        init = 1'b1; cnt_wr = 1'b1; cnt_wdata = 32'd7;
        @(negedge clk);
        init = 1'b0; cnt_wr = 1'b0;
        chk(cur_count == 0, "R9 init wins over write", cur_count, 0);
        count_irq(20, h);
        chk(h == 0, "R9 pending expiry cancelled", h, 0);
        wr_count(3);
        step(2);
        chk(cur_count == 1, "R9 divisor back to one", cur_count, 1);
        count_irq(10, h);
        chk(h == 0, "R9 entry masked", h, 0);
    endtask

    task automatic t_align();
        wr_lvt(1'b1, 1'b0, 8'h00);
        wr_div(1);
        wr_count(3);
        for (int j = 0; j < 16; j++) begin
            chk(cur_count == CNT_W'(3 - (j >> 2)), "R11 load-aligned ticks", cur_count, 3 - (j >> 2));
            chk(cur_count == CNT_W'(3 - (j >> 2)) || j != 0, "R3 load value", cur_count, 3);
            @(negedge clk);
        end
    endtask

    bit done = 1'b0;

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_divmap();
        t_periodic();
        t_mode();
        t_zero();
        t_mask();
        t_init();
        t_align();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule